// File: doc/BRIEF.md
# Guarded-Action Routing Stage

This block moves 32-bit packets from two input streams to two output streams. Each input stream feeds a small local queue. Every cycle a scheduler looks at the two queue heads and at the free space in the two output registers. It then fires at most one action, and that action always runs to completion in the cycle it fires.

An action either discards a bad packet or routes a good packet. A packet is bad when its top bit is set. Discarding a bad packet pops it from its queue and adds one to a running counter. A good packet goes to the output selected by its lowest bit, and it is routed only when that output's register can take it in the same cycle. Discards win over routing. Between the two inputs, routing alternates through a one-bit preference that changes only when a packet is routed.

Top module: `gact_router`

## Requirements
- R1: After reset both outputs are not valid, the bad-packet count is zero, both input readies are high, and the routing preference points at input 0.
- R2: A packet with bit 31 clear leaves on output 0 when its bit 0 is 0 and on output 1 when its bit 0 is 1, with its value unchanged, one cycle after it is routed.
- R3: A packet with bit 31 set is removed from its queue, never appears on an output, and raises the bad-packet count by exactly one in the cycle after it is removed.
- R4: At most one packet in total is taken from the two input queues per cycle.
- R5: A packet is routed only when its target output is empty or is being read in that cycle. While an output is valid and not read, its data and valid stay unchanged.
- R6: A bad packet at the head of input 0 is removed before any other action. Otherwise a bad packet at the head of input 1 is removed before any routing.
- R7: When both heads are good and both targets have room, routing alternates between the inputs, starting with input 0 after reset.
- R8: If the preferred input cannot route because its target is full, the other input routes in that cycle when its own target has room. The preference changes only when a packet is routed, to point at the input that was not served.
- R9: Each input queue holds DEPTH packets. Its ready output is low exactly while it holds DEPTH packets, and an offer made while ready is low is not taken.
- R10: Packets from one input that go to the same output keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2 | Offer valid, one bit per input |
| in_ready | output | 2 | Input queue has room, one bit per input |
| in_data | input | 2x DW | Offered packet, one word per input |
| out_valid | output | 2 | Output register holds a packet |
| out_ready | input | 2 | Downstream takes the packet |
| out_data | output | 2x DW | Output packet, one word per output |
| bad_count | output | CNT_W | Number of discarded packets |

## Verification
The bench builds the block with its defaults: 32-bit packets, a queue depth of 4 and a 16-bit counter. At depth 4, either queue fills within a few cycles when the outputs stall, so the full-queue refusal and the blocked-preference fallback come up often. The bench's phases vary the bad-packet rate and the output stall rate. These cover each priority level on its own, both heads bad together, and both heads aiming at the same full output.

// File: rtl/gact_pkg.sv
package gact_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_KILL0,
    ACT_KILL1,
    ACT_ROUTE0,
    ACT_ROUTE1
  } act_e;
endpackage

// File: rtl/gact_fifo.sv
module gact_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          nonempty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> nonempty);
endmodule

// File: rtl/gact_sched.sv
module gact_sched
  import gact_pkg::*;
(
  input  logic [1:0] has,
  input  logic [1:0] mark,
  input  logic [1:0] dest,
  input  logic [1:0] space,
  input  logic       pref,
  output act_e       act
);
  logic [1:0] kill_ok, route_ok;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      kill_ok[i]  = has[i] && mark[i];
      route_ok[i] = has[i] && !mark[i] && space[dest[i]];
    end
    if (kill_ok[0])      act = ACT_KILL0;
    else if (kill_ok[1]) act = ACT_KILL1;
    else if (!pref) begin
      if (route_ok[0])      act = ACT_ROUTE0;
      else if (route_ok[1]) act = ACT_ROUTE1;
      else                  act = ACT_NONE;
    end else begin
      if (route_ok[1])      act = ACT_ROUTE1;
      else if (route_ok[0]) act = ACT_ROUTE0;
      else                  act = ACT_NONE;
    end
  end
endmodule

// File: rtl/gact_outreg.sv
module gact_outreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          space
);
  assign space = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (push)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) data <= push_data;
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(data));

  // R5
  push_space_chk: assert property (@(posedge clk) disable iff (rst) push |-> space);
endmodule

// File: rtl/gact_router.sv
module gact_router
  import gact_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 16,
  parameter int DEST_BIT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          in_valid,
  output logic [1:0]          in_ready,
  input  logic [1:0][DW-1:0]  in_data,
  output logic [1:0]          out_valid,
  input  logic [1:0]          out_ready,
  output logic [1:0][DW-1:0]  out_data,
  output logic [CNT_W-1:0]    bad_count
);
  localparam int MARK_BIT = DW - 1;

  logic [1:0][DW-1:0] head;
  logic [1:0]         has, full, pop, mark, dest, space, opush;
  logic               pref;
  logic [DW-1:0]      route_data;
  logic               routing, killing;
  act_e               act;

  for (genvar i = 0; i < 2; i++) begin : g_in
    gact_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .push(in_valid[i]), .push_data(in_data[i]),
      .pop(pop[i]), .head(head[i]),
      .nonempty(has[i]), .full(full[i])
    );
    assign in_ready[i] = !full[i];
    assign mark[i]     = head[i][MARK_BIT];
    assign dest[i]     = head[i][DEST_BIT];
  end

  gact_sched u_sched (
    .has(has), .mark(mark), .dest(dest), .space(space), .pref(pref), .act(act)
  );

  assign pop[0]     = (act == ACT_KILL0) || (act == ACT_ROUTE0);
  assign pop[1]     = (act == ACT_KILL1) || (act == ACT_ROUTE1);
  assign routing    = (act == ACT_ROUTE0) || (act == ACT_ROUTE1);
  assign killing    = (act == ACT_KILL0) || (act == ACT_KILL1);
  assign route_data = (act == ACT_ROUTE1) ? head[1] : head[0];

  always_comb begin
    opush = '0;
    if (routing) opush[route_data[DEST_BIT]] = 1'b1;
  end

  for (genvar k = 0; k < 2; k++) begin : g_out
    gact_outreg #(.DW(DW)) u_o (
      .clk(clk), .rst(rst),
      .push(opush[k]), .push_data(route_data),
      .ready(out_ready[k]), .valid(out_valid[k]),
      .data(out_data[k]), .space(space[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pref      <= 1'b0;
      bad_count <= '0;
    end else begin
      if (act == ACT_ROUTE0)      pref <= 1'b1;
      else if (act == ACT_ROUTE1) pref <= 1'b0;
      if (killing) bad_count <= bad_count + 1'b1;
    end
  end

  // R4
  single_pop_chk: assert property (@(posedge clk) disable iff (rst) $countones(pop) <= 1);

  // R6
  kill_first_chk: assert property (@(posedge clk) disable iff (rst)
    has[0] && head[0][MARK_BIT] |-> pop[0]);

  // R3
  kill_count_chk: assert property (@(posedge clk) disable iff (rst)
    killing |=> bad_count == $past(bad_count) + 1'b1);

  // R2
  dest1_chk: assert property (@(posedge clk) disable iff (rst)
    opush[1] |=> out_valid[1] && out_data[1][DEST_BIT]);

  // R2
  dest0_chk: assert property (@(posedge clk) disable iff (rst)
    opush[0] |=> out_valid[0] && !out_data[0][DEST_BIT]);

  // R8
  pref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !routing |=> $stable(pref));
endmodule

// File: tb/gact_router_tb.sv
`timescale 1ns/1ps
module gact_router_tb;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] in_valid = '0;
  logic [1:0] in_ready;
  logic [1:0][DW-1:0] in_data = '0;
  logic [1:0] out_valid;
  logic [1:0] out_ready = '0;
  logic [1:0][DW-1:0] out_data;
  logic [CNT_W-1:0] bad_count;

  gact_router #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W), .DEST_BIT(0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .bad_count(bad_count)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  // behavioural reference
  logic [31:0] mq0[$];
  logic [31:0] mq1[$];
  logic [1:0] mov;
  logic [31:0] mod0, mod1;
  logic mrr;
  logic [CNT_W-1:0] mcnt;
  logic [1:0] acc;

  always @(posedge clk) begin
    if (rst) begin
      mq0.delete(); mq1.delete();
      mov = '0; mrr = 1'b0; mcnt = '0; acc = '0;
    end else begin
      logic [1:0] sp;
      logic h0v, h1v, c0, c1;
      logic [31:0] h0, h1, rd;
      int act;
      sp[0] = !mov[0] || out_ready[0];
      sp[1] = !mov[1] || out_ready[1];
      h0v = mq0.size() > 0; h1v = mq1.size() > 0;
      h0 = h0v ? mq0[0] : 32'h0; h1 = h1v ? mq1[0] : 32'h0;
      acc[0] = in_valid[0] && (mq0.size() < DEPTH);
      acc[1] = in_valid[1] && (mq1.size() < DEPTH);
      act = 0;
      if (h0v && h0[31]) act = 1;
      else if (h1v && h1[31]) act = 2;
      else begin
        c0 = h0v && sp[h0[0]];
        c1 = h1v && sp[h1[0]];
        if (!mrr) act = c0 ? 3 : (c1 ? 4 : 0);
        else      act = c1 ? 4 : (c0 ? 3 : 0);
      end
      for (int k = 0; k < 2; k++) if (out_ready[k]) mov[k] = 1'b0;
      rd = (act == 4) ? h1 : h0;
      if (act >= 3) begin
        mov[rd[0]] = 1'b1;
        if (rd[0]) mod1 = rd; else mod0 = rd;
        mrr = (act == 3);
      end
      if (act == 1 || act == 3) void'(mq0.pop_front());
      if (act == 2 || act == 4) void'(mq1.pop_front());
      if (act == 1 || act == 2) mcnt = mcnt + 1'b1;
      if (acc[0]) mq0.push_back(in_data[0]);
      if (acc[1]) mq1.push_back(in_data[1]);
    end
  end

  task automatic chk(input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("in_ready(R9)", 32'(in_ready), {30'd0, mq1.size() < DEPTH, mq0.size() < DEPTH});
    chk("out_valid(R5)", 32'(out_valid), 32'(mov));
    if (mov[0]) chk("out0 data(R2,R10)", out_data[0], mod0);
    if (mov[1]) chk("out1 data(R2,R10)", out_data[1], mod1);
    chk("bad_count(R3)", 32'(bad_count), 32'(mcnt));
  endtask

  int vld_pct, kill_pct, rdy_pct, dest_mode;
  logic [1:0] offered = '0;
  int seq = 0;

  task automatic drive();
    for (int i = 0; i < 2; i++) begin
      if (!offered[i] || acc[i]) begin
        if (($urandom % 100) < vld_pct) begin
          logic [31:0] d;
          seq++;
          d = {(($urandom % 100) < kill_pct) ? 1'b1 : 1'b0, 7'(i), 16'(seq), 7'($urandom), 1'b0};
          case (dest_mode)
            0: d[0] = 1'($urandom);
            1: d[0] = 1'b0;
            default: d[0] = 1'(i);
          endcase
          in_data[i] = d;
          in_valid[i] = 1'b1;
          offered[i] = 1'b1;
        end else begin
          in_valid[i] = 1'b0;
          offered[i] = 1'b0;
        end
      end
    end
    for (int k = 0; k < 2; k++) out_ready[k] = (($urandom % 100) < rdy_pct);
  endtask

  task automatic run(input string t, input int n, input int v, input int kp, input int rp, input int dm);
    tag = t; vld_pct = v; kill_pct = kp; rdy_pct = rp; dest_mode = dm;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      drive();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    tag = "R1";
    chk("out_valid", 32'(out_valid), 32'd0);
    chk("bad_count", 32'(bad_count), 32'd0);
    chk("in_ready", 32'(in_ready), 32'd3);
    // R7: first route after reset comes from input 0
    in_data[0] = 32'h0000_0010; in_data[1] = 32'h0000_0021;
    in_valid = 2'b11; out_ready = 2'b11;
    @(negedge clk);
    in_valid = 2'b00;
    @(negedge clk);
    tag = "R7";
    chk("first route from input 0", 32'(out_valid), 32'd1);
    chk("first route data", out_data[0], 32'h0000_0010);
    @(negedge clk);
    chk("second route from input 1", out_data[1], 32'h0000_0021);
    repeat (3) @(negedge clk);
    compare_all();
    // R2 R10: good packets only, free outputs
    run("R2", 400, 70, 0, 100, 0);
    // R3: mostly bad packets
    run("R3", 400, 80, 60, 90, 0);
    // R6: both inputs busy, many bad heads, stalled outputs
    run("R6", 400, 95, 40, 30, 0);
    // R7: both routable to distinct outputs
    run("R7", 400, 100, 0, 100, 2);
    // R8: both aim at output 0 which stalls often
    run("R8", 400, 100, 0, 40, 1);
    // R8: random destinations, heavy stalls give blocked preferences
    run("R8", 400, 90, 10, 25, 0);
    // R9 R5: outputs stalled, queues fill
    run("R9", 300, 100, 5, 5, 0);
    // R4 R10: mixed traffic
    run("R4", 1500, 60, 20, 60, 0);
    run("R10", 600, 85, 0, 50, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule